// File: doc/BRIEF.md
# Multi-Mode Synthesizer Configuration Interface

This block holds the divider settings of an integer-N frequency synthesizer. These are the main divider M, the swallow count A, the reference divider R and an active-low prescaler enable. It also holds an 8-bit enhancement byte. A host loads the settings in one of three ways, chosen by two mode pins. The first is a bit-serial shift port. The second is byte-wide strobed writes that each fill part of the word. The third is a set of direct pins that drive the divider values with no storage between them and the outputs.

The settings are double-buffered. Writes go to a 20-bit primary word. A transfer copies the primary word into a secondary word. The transfer fires on the rising edge of the serial load enable or on the rising edge of a hop strobe. A per-mode select line chooses which of the two words drives the counter outputs, so a frequency hop can be staged in advance and applied in a single step.

Every strobe, every serial line and the data byte pass through a two-flop synchronizer to the system clock. Each strobe is then edge-detected, so every register update is synchronous to that clock.

The primary word is laid out as follows:

| Bits | Field |
|------|-------|
| 19 | prescaler enable |
| 18:10 | M[8:0] |
| 9:6 | A[3:0] |
| 5:0 | R[5:0] |

Top module: `synth_cfg_if`

## Requirements
- R1: `modeDirect`=1 selects direct mode whatever `modeSerial` is. With `modeDirect`=0, `modeSerial`=1 selects serial mode and `modeSerial`=0 selects parallel mode.
- R2: In serial mode with `serEnhSel` low, each rising edge of `serClk` shifts `serData` into the primary word at bit 0, so the first bit shifted ends at bit 19. The shift happens only while `serLoadN` is low. Edges of `serClk` while `serLoadN` is high change nothing.
- R3: In serial mode with `serEnhSel` high, each rising edge of `serClk` shifts `serData` into the enhancement byte at bit 0, most significant bit first, and the primary word is not changed.
- R4: The primary word is copied into the secondary word on a rising edge of `serLoadN` in serial mode, or on a rising edge of `hopWr` in serial or parallel mode.
- R5: In serial mode `selSerial`, and in parallel mode `selParallel`, chooses the word that drives `outPreN`/`outM`/`outA`/`outR`: 1 selects the primary word and 0 selects the secondary word.
- R6: In parallel mode, the rising edges of the three strobes load the primary word as follows:

  | Strobe | Source bits | Destination fields |
  |--------|-------------|--------------------|
  | `m1Wr` | busData[7] | prescaler enable |
  | `m1Wr` | busData[6:0] | M[6:0] |
  | `m2Wr` | busData[3:2] | R[5:4] |
  | `m2Wr` | busData[1:0] | M[8:7] |
  | `aWr` | busData[7:4] | R[3:0] |
  | `aWr` | busData[3:0] | A[3:0] |

- R7: In parallel mode, a rising edge of `serEnhSel` loads `busData[7:0]` into the enhancement byte.
- R8: In direct mode the following hold:
  - `outM`, `outA` and `outPreN` follow `directM`, `directA` and `directPreN`.
  - `outR` is zero.
  - Strobes and serial clocks leave the primary and secondary words unchanged.
- R9: Reset clears the primary, secondary and enhancement registers, so every output reads zero in serial or parallel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeDirect | input | 1 | Direct-mode select |
| modeSerial | input | 1 | Serial (1) or parallel (0) when not direct |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data, MSB first |
| serLoadN | input | 1 | Serial load enable, active low; rising edge transfers |
| serEnhSel | input | 1 | Serial: target enhancement byte; parallel: enhancement write strobe |
| busData | input | 8 | Parallel data byte |
| m1Wr | input | 1 | Parallel write strobe for prescaler enable and M[6:0] |
| m2Wr | input | 1 | Parallel write strobe for R[5:4] and M[8:7] |
| aWr | input | 1 | Parallel write strobe for R[3:0] and A |
| hopWr | input | 1 | Primary-to-secondary transfer strobe |
| selSerial | input | 1 | Word select in serial mode |
| selParallel | input | 1 | Word select in parallel mode |
| directM | input | 9 | M value in direct mode |
| directA | input | 4 | A value in direct mode |
| directPreN | input | 1 | Prescaler enable in direct mode |
| outM | output | 9 | M counter value |
| outA | output | 4 | A counter value |
| outR | output | 6 | R counter value |
| outPreN | output | 1 | Prescaler enable, active low |
| outEnh | output | 8 | Enhancement byte |

## Verification
Full random 20-bit serial words are shifted in and read back through both the primary and secondary selections. This separates a bit-order or layout error from a broken transfer. Random sequences of the three parallel strobes, with random bytes, exercise each field split on its own, so a swapped nibble or a mis-placed M bit shows up in a single field. Directed cases cover the following:
- serial clocks pulsed while the load enable is high;
- enhancement shifts, which must leave the primary word alone;
- strobes issued in direct mode, then read back in parallel mode;
- the mode-select priority;
- the all-zero state after reset.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W   = 9;
  localparam int A_W   = 4;
  localparam int R_W   = 6;
  localparam int ENH_W = 8;
  localparam int BUS_W = 8;
  localparam int PRIM_W = 1 + M_W + A_W + R_W;
  localparam int R_LO   = 0;
  localparam int A_LO   = R_LO + R_W;
  localparam int M_LO   = A_LO + A_W;
  localparam int PRE_POS = M_LO + M_W;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_PARALLEL = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_DIRECT   = 2'd2
  } cfgMode_e;

  typedef struct packed {
    cfgMode_e          mode;
    logic              shiftPrim;
    logic              shiftEnh;
    logic              shiftBit;
    logic              xfer;
    logic              wrM1;
    logic              wrM2;
    logic              wrA;
    logic              wrEnh;
    logic [BUS_W-1:0]  busByte;
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeDirect,
  input  logic              modeSerial,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoadN,
  input  logic              serEnhSel,
  input  logic [BUS_W-1:0]  busData,
  input  logic              m1Wr,
  input  logic              m2Wr,
  input  logic              aWr,
  input  logic              hopWr,
  output cfgStrobe_t        strb
);
  localparam int CTL_W = 8;
  localparam int B_SCLK = 0, B_SDAT = 1, B_LOADN = 2, B_ENH = 3;
  localparam int B_M1 = 4, B_M2 = 5, B_A = 6, B_HOP = 7;

  logic [CTL_W-1:0] ctlRaw, ctlSync, ctlPrev, ctlRise;
  logic [BUS_W-1:0] busSync;
  cfgMode_e         mode;

  assign ctlRaw = {hopWr, aWr, m2Wr, m1Wr, serEnhSel, serLoadN, serData, serClk};

  synth_cfg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) ctlSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(ctlRaw), .syncOut(ctlSync));

  synth_cfg_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) busSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(busData), .syncOut(busSync));

  always_ff @(posedge clk) begin
    if (!rstN) ctlPrev <= '0;
    else       ctlPrev <= ctlSync;
  end

  assign ctlRise = ctlSync & ~ctlPrev;

  always_comb begin
    if (modeDirect)      mode = MODE_DIRECT;
    else if (modeSerial) mode = MODE_SERIAL;
    else                 mode = MODE_PARALLEL;
  end

  always_comb begin
    logic isSer, isPar, serShift;
    isSer    = (mode == MODE_SERIAL);
    isPar    = (mode == MODE_PARALLEL);
    serShift = isSer && ctlRise[B_SCLK] && !ctlSync[B_LOADN];
    strb.mode      = mode;
    strb.shiftPrim = serShift && !ctlSync[B_ENH];
    strb.shiftEnh  = serShift &&  ctlSync[B_ENH];
    strb.shiftBit  = ctlSync[B_SDAT];
    strb.xfer      = (isSer && ctlRise[B_LOADN]) || ((isSer || isPar) && ctlRise[B_HOP]);
    strb.wrM1      = isPar && ctlRise[B_M1];
    strb.wrM2      = isPar && ctlRise[B_M2];
    strb.wrA       = isPar && ctlRise[B_A];
    strb.wrEnh     = isPar && ctlRise[B_ENH];
    strb.busByte   = busSync;
  end

  // R2/R3: the two serial targets never shift in the same cycle
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftPrim && strb.shiftEnh));
  // R1: a direct-mode pin setting never yields a write strobe
  a_r1_direct_quiet: assert property (@(posedge clk) disable iff (!rstN)
    modeDirect |-> !(strb.wrM1 || strb.wrM2 || strb.wrA || strb.shiftPrim || strb.xfer));
endmodule

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic              selSerial,
  input  logic              selParallel,
  input  logic [M_W-1:0]    directM,
  input  logic [A_W-1:0]    directA,
  input  logic              directPreN,
  output logic [M_W-1:0]    outM,
  output logic [A_W-1:0]    outA,
  output logic [R_W-1:0]    outR,
  output logic              outPreN,
  output logic [ENH_W-1:0]  outEnh
);
  localparam int M1_MBITS = BUS_W - 1;
  localparam int M2_MBITS = M_W - M1_MBITS;
  localparam int M2_RBITS = R_W - 4;
  localparam int A_RBITS  = BUS_W - A_W;

  logic [PRIM_W-1:0] primWord, secWord, activeWord;
  logic [ENH_W-1:0]  enhReg;
  logic              useSec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primWord <= '0;
      secWord  <= '0;
      enhReg   <= '0;
    end else begin
      if (strb.shiftPrim) primWord <= {primWord[PRIM_W-2:0], strb.shiftBit};
      if (strb.wrM1) begin
        primWord[PRE_POS]           <= strb.busByte[BUS_W-1];
        primWord[M_LO +: M1_MBITS]  <= strb.busByte[M1_MBITS-1:0];
      end
      if (strb.wrM2) begin
        primWord[R_LO+A_RBITS +: M2_RBITS] <= strb.busByte[M2_MBITS +: M2_RBITS];
        primWord[M_LO+M1_MBITS +: M2_MBITS] <= strb.busByte[M2_MBITS-1:0];
      end
      if (strb.wrA) begin
        primWord[R_LO +: A_RBITS] <= strb.busByte[A_W +: A_RBITS];
        primWord[A_LO +: A_W]     <= strb.busByte[A_W-1:0];
      end
      if (strb.xfer) secWord <= primWord;
      if (strb.shiftEnh)   enhReg <= {enhReg[ENH_W-2:0], strb.shiftBit};
      else if (strb.wrEnh) enhReg <= strb.busByte[ENH_W-1:0];
    end
  end

  always_comb begin
    useSec     = (strb.mode == MODE_SERIAL) ? !selSerial : !selParallel;
    activeWord = useSec ? secWord : primWord;
    if (strb.mode == MODE_DIRECT) begin
      outM    = directM;
      outA    = directA;
      outR    = '0;
      outPreN = directPreN;
    end else begin
      outM    = activeWord[M_LO +: M_W];
      outA    = activeWord[A_LO +: A_W];
      outR    = activeWord[R_LO +: R_W];
      outPreN = activeWord[PRE_POS];
    end
  end
  assign outEnh = enhReg;

  // R4: transfer captures the primary word as it stood
  a_r4_hop_copy: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> secWord == $past(primWord));
  // R2: a serial shift moves the word up by one and enters the new bit at bit 0
  a_r2_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftPrim |=> primWord == {$past(primWord[PRIM_W-2:0]), $past(strb.shiftBit)});
  // R3: enhancement shifting leaves the primary word alone
  a_r3_prim_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEnh && !strb.wrM1 && !strb.wrM2 && !strb.wrA) |=> $stable(primWord));
  // R8: direct mode stores nothing
  a_r8_direct_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode == MODE_DIRECT) |=> ($stable(primWord) && $stable(secWord)));
  // R6: M1 strobe lands in prescaler enable and low M bits
  a_r6_m1_field: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrM1 |=> primWord[PRE_POS] == $past(strb.busByte[BUS_W-1]));
  // R7: enhancement byte only moves on a shift or write
  a_r7_enh_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftEnh || strb.wrEnh) |=> $stable(enhReg));
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeDirect,
  input  logic              modeSerial,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoadN,
  input  logic              serEnhSel,
  input  logic [BUS_W-1:0]  busData,
  input  logic              m1Wr,
  input  logic              m2Wr,
  input  logic              aWr,
  input  logic              hopWr,
  input  logic              selSerial,
  input  logic              selParallel,
  input  logic [M_W-1:0]    directM,
  input  logic [A_W-1:0]    directA,
  input  logic              directPreN,
  output logic [M_W-1:0]    outM,
  output logic [A_W-1:0]    outA,
  output logic [R_W-1:0]    outR,
  output logic              outPreN,
  output logic [ENH_W-1:0]  outEnh
);
  cfgStrobe_t strb;

  synth_cfg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeDirect(modeDirect), .modeSerial(modeSerial),
    .serClk(serClk), .serData(serData), .serLoadN(serLoadN), .serEnhSel(serEnhSel),
    .busData(busData), .m1Wr(m1Wr), .m2Wr(m2Wr), .aWr(aWr), .hopWr(hopWr),
    .strb(strb));

  synth_cfg_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .selSerial(selSerial),
    .selParallel(selParallel), .directM(directM), .directA(directA),
    .directPreN(directPreN), .outM(outM), .outA(outA), .outR(outR),
    .outPreN(outPreN), .outEnh(outEnh));
endmodule

// File: tb/synth_cfg_if_tb.sv
module synth_cfg_if_tb_top;
  logic clk = 0, rstN = 0;
  logic modeDirect = 0, modeSerial = 1;
  logic serClk = 0, serData = 0, serLoadN = 1, serEnhSel = 0;
  logic [7:0] busData = 0;
  logic m1Wr = 0, m2Wr = 0, aWr = 0, hopWr = 0;
  logic selSerial = 1, selParallel = 1;
  logic [8:0] directM = 0;
  logic [3:0] directA = 0;
  logic directPreN = 0;
  logic [8:0] outM;
  logic [3:0] outA;
  logic [5:0] outR;
  logic outPreN;
  logic [7:0] outEnh;

  int nChecks = 0, nFail = 0;
  logic [19:0] modPrim = 0, modSec = 0;
  logic [7:0]  modEnh = 0;

  always #4 clk = ~clk;

  synth_cfg_if dut_i (.*);

  function automatic logic [19:0] expWord();
    if (modeDirect) return {directPreN, directM, directA, 6'b0};
    if (modeSerial) return selSerial ? modPrim : modSec;
    return selParallel ? modPrim : modSec;
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag);
    logic [19:0] act, exp;
    act = {outPreN, outM, outA, outR};
    exp = expWord();
    nChecks++;
    if (act !== exp || outEnh !== modEnh) begin
      nFail++;
      $display("FAIL %s: word %h enh %h, expected word %h enh %h", tag, act, outEnh, exp, modEnh);
    end
  endtask

  task automatic serBit(logic b);
    serData = b;   waitClk(4);
    serClk = 1;    waitClk(4);
    serClk = 0;    waitClk(4);
  endtask

  // shift n bits of w (MSB first), then raise load enable to transfer
  task automatic serialLoad(logic [19:0] w, int n, logic toEnh);
    serEnhSel = toEnh; serLoadN = 0; waitClk(4);
    for (int i = n - 1; i >= 0; i--) begin
      serBit(w[i]);
      if (toEnh) modEnh = {modEnh[6:0], w[i]};
      else       modPrim = {modPrim[18:0], w[i]};
    end
    serLoadN = 1; waitClk(6);
    modSec = modPrim;
    serEnhSel = 0; waitClk(4);
  endtask

  // which: 0=M1 1=M2 2=A 3=enh 4=hop
  task automatic parWrite(int which, logic [7:0] d, logic applyModel);
    busData = d; waitClk(4);
    case (which)
      0: m1Wr = 1; 1: m2Wr = 1; 2: aWr = 1; 3: serEnhSel = 1; default: hopWr = 1;
    endcase
    waitClk(5);
    {m1Wr, m2Wr, aWr, serEnhSel, hopWr} = '0;
    waitClk(5);
    if (applyModel) case (which)
      0: begin modPrim[19] = d[7]; modPrim[16:10] = d[6:0]; end
      1: begin modPrim[5:4] = d[3:2]; modPrim[18:17] = d[1:0]; end
      2: begin modPrim[3:0] = d[7:4]; modPrim[9:6] = d[3:0]; end
      3: modEnh = d;
      default: modSec = modPrim;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    waitClk(5); rstN = 1; waitClk(4);
    check("R9 reset serial primary");
    selSerial = 0; waitClk(1); check("R9 reset serial secondary");

    // R2: full serial words, read primary and secondary
    for (int k = 0; k < 5; k++) begin
      logic [19:0] w;
      w = 20'($urandom);
      serialLoad(w, 20, 0);
      selSerial = 1; waitClk(1); check("R2 serial primary");
      selSerial = 0; waitClk(1); check("R4 serial secondary after load edge");
    end
    // R2: clocks while load enable high are ignored
    selSerial = 1; serData = 1;
    for (int k = 0; k < 3; k++) begin serClk = 1; waitClk(4); serClk = 0; waitClk(4); end
    check("R2 clocks ignored with load high");
    // R3: enhancement shift leaves primary alone
    serialLoad(20'hA5, 8, 1);
    check("R3 enhancement shifted, primary held");

    // R1 / R5 / R6 / R7: parallel mode
    modeSerial = 0; selParallel = 1; waitClk(4);
    check("R1 parallel select");
    for (int k = 0; k < 30; k++) begin
      int which;
      which = int'($urandom % 5);
      parWrite(which, 8'($urandom), 1);
      selParallel = 1; waitClk(1); check("R6 parallel write primary");
      selParallel = 0; waitClk(1); check("R5 parallel secondary");
      selParallel = 1;
    end
    parWrite(0, 8'hFF, 1); parWrite(1, 8'h0F, 1); parWrite(2, 8'hFF, 1);
    check("R6 all-ones fields");
    parWrite(3, 8'h3C, 1); check("R7 parallel enhancement write");
    parWrite(4, 8'h00, 1); selParallel = 0; waitClk(1); check("R4 hop transfer");
    // R5: serial select line has no effect in parallel mode
    selSerial = ~selParallel; waitClk(1); check("R5 serial select ignored in parallel");

    // R8: direct mode
    modeDirect = 1; directM = 9'h1A7; directA = 4'h9; directPreN = 1; waitClk(2);
    check("R8 direct pins, R zero");
    modeSerial = 1; waitClk(1); check("R1 direct has priority");
    modeSerial = 0;
    parWrite(0, 8'h00, 0); parWrite(2, 8'h00, 0); parWrite(4, 8'h00, 0);
    modeDirect = 0; selParallel = 1; waitClk(2);
    check("R8 strobes ignored in direct (primary)");
    selParallel = 0; waitClk(1); check("R8 strobes ignored in direct (secondary)");

    // R9: reset again
    rstN = 0; waitClk(3); rstN = 1; modPrim = 0; modSec = 0; modEnh = 0; waitClk(4);
    selParallel = 1; waitClk(1); check("R9 reset clears primary");
    selParallel = 0; waitClk(1); check("R9 reset clears secondary");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule